// File: doc/BRIEF.md
# Real-Time Clock with Alarms and Stopwatch

This block keeps elapsed time as seconds, minutes, hours and a free-running day count, with no calendar. A clock enable pulsing at 32.768 kHz feeds a prescaler. The prescaler emits one tick per second. Each tick advances the cascaded counters, and the day count wraps to zero after its last value.

Seven events can each raise a sticky interrupt flag, and each has its own enable bit:

- a second tick
- a minute rollover
- an hour rollover
- a day rollover
- a time-of-day alarm
- a day-plus-time alarm
- a countdown stopwatch that underflows

A small synchronous register interface loads the time, both alarm targets and the stopwatch. The same interface reads back every register. A single interrupt line is high while any flag is set.

Register map, selected by a 3-bit address:

| Address | Register |
|---|---|
| 0 | current time |
| 1 | time-of-day alarm |
| 2 | day-plus-time alarm |
| 3 | stopwatch |
| 4 | interrupt enables |
| 5 | interrupt flags |

A time word carries the second in bits [5:0], the minute in bits [11:6], the hour in bits [16:12] and the day from bit 17 upward.

Interrupt enable and flag bits:

| Bit | Event |
|---|---|
| 0 | second tick |
| 1 | minute rollover |
| 2 | hour rollover |
| 3 | day rollover |
| 4 | time-of-day alarm |
| 5 | day-plus-time alarm |
| 6 | stopwatch underflow |

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A one-second tick occurs on every PRESCALE-th edge at which `tick_en` is high. A write to address 0 restarts the prescaler, so the first tick after the write comes PRESCALE enabled edges later.
- R3: Each tick advances the time counters.
  - Seconds run 0..59 and minutes run 0..59, each carrying into the next field.
  - Hours run 0..23 and carry into the day.
  - Address 0 reads the time as second [5:0], minute [11:6], hour [16:12] and day [31:17].
  - A loaded field above its maximum is clamped to that maximum.
- R4: The day count runs from 0 to 2^DAY_W-1 and wraps to 0 on the tick after 23:59:59 of the last day.
- R5: On a tick, flag bit 0 is set. A minute rollover sets bit 1, an hour rollover sets bit 2 and a day rollover sets bit 3. Each flag is set only while its enable bit at address 4 is one.
- R6: On the cycle after each tick, the time-of-day alarm at address 1 (hour, minute and second fields of a time word) is compared with the updated time. A match sets flag bit 4 when enabled, so the alarm fires once per day at that time.
- R7: The day-plus-time alarm at address 2 (full time word) also compares the day and sets flag bit 5 when enabled, so it matches only once.
- R8: Writing N to address 3 loads the stopwatch, which then runs. Each tick decrements it. The tick that finds it at zero stops it and sets flag bit 6 when enabled. Address 3 reads the count in [SW_W-1:0] and the run state in bit SW_W.
- R9: Flags at address 5 are sticky and are cleared by writing one to each bit to clear. `irq` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 17+DAY_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 17+DAY_W | Combinational read data |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
The bench counts enabled edges between a time load and the first second change. A prescaler whose phase is not cleared by the load would give a count other than PRESCALE.

It loads 23:59:58 on the final day and rides through the wrap. A broken carry chain or day limit shows as a nonzero time or missing rollover flags.

The alarm is checked again one second after it matches, which catches an alarm that keeps firing. The stopwatch is loaded with 3 and observed after the third and fourth ticks, which catches off-by-one underflow. Cleared enable bits must leave flags at zero across a minute rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      REG_TIME       = 3'd0,
      REG_ALARM_TOD  = 3'd1,
      REG_ALARM_FULL = 3'd2,
      REG_STOPWATCH  = 3'd3,
      REG_IRQ_EN     = 3'd4,
      REG_IRQ_FLAG   = 3'd5
   } reg_addr_e;

   localparam int SEC_W   = 6;
   localparam int MIN_W   = 6;
   localparam int HOUR_W  = 5;
   localparam int TOD_W   = SEC_W + MIN_W + HOUR_W;
   localparam int SEC_MAX  = 59;
   localparam int MIN_MAX  = 59;
   localparam int HOUR_MAX = 23;

   localparam int NUM_IRQ  = 7;
   localparam int IRQ_SEC  = 0;
   localparam int IRQ_MIN  = 1;
   localparam int IRQ_HOUR = 2;
   localparam int IRQ_DAY  = 3;
   localparam int IRQ_ALMA = 4;
   localparam int IRQ_ALMB = 5;
   localparam int IRQ_SW   = 6;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768,
   localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   output logic tick
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("rtc_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] phase_q;

   assign tick = tick_en & ~restart & (phase_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (tick_en) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + CNT_W'(1);
      end
   end

   assert_restart_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);

   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
   parameter int W   = 6,
   parameter int MAX = 59
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         at_max
);

   localparam logic [W-1:0] TOP = W'(MAX);

   generate
      if (MAX < 1 || longint'(MAX) > (longint'(1) << W) - 1) begin : g_bad_max
         $error("rtc_wrap_counter: MAX does not fit in W bits");
      end
   endgenerate

   assign at_max = (value >= TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (load) begin
         value <= (load_val > TOP) ? TOP : load_val;
      end else if (step) begin
         value <= at_max ? '0 : value + W'(1);
      end
   end

   assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      value <= TOP);

   assert_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value == TOP) |=> value == '0);

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
   import rtc_pkg::*;
#(
   parameter int DAY_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [SEC_W-1:0]  ld_sec,
   input  logic [MIN_W-1:0]  ld_min,
   input  logic [HOUR_W-1:0] ld_hour,
   input  logic [DAY_W-1:0]  ld_day,
   output logic [SEC_W-1:0]  sec,
   output logic [MIN_W-1:0]  min,
   output logic [HOUR_W-1:0] hour,
   output logic [DAY_W-1:0]  day,
   output logic              roll_sec,
   output logic              roll_min,
   output logic              roll_hour,
   output logic              roll_day
);

   localparam int DAY_MAX = (1 << DAY_W) - 1;

   generate
      if (DAY_W < 1 || DAY_W > 30) begin : g_bad_day
         $error("rtc_counters: DAY_W out of range");
      end
   endgenerate

   logic sec_top, min_top, hour_top, day_top;
   logic step_min, step_hour, step_day;

   assign step_min  = tick & sec_top;
   assign step_hour = step_min & min_top;
   assign step_day  = step_hour & hour_top;

   rtc_wrap_counter #(.W(SEC_W), .MAX(SEC_MAX)) u_sec (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_sec),
      .step(tick), .value(sec), .at_max(sec_top));

   rtc_wrap_counter #(.W(MIN_W), .MAX(MIN_MAX)) u_min (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_min),
      .step(step_min), .value(min), .at_max(min_top));

   rtc_wrap_counter #(.W(HOUR_W), .MAX(HOUR_MAX)) u_hour (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_hour),
      .step(step_hour), .value(hour), .at_max(hour_top));

   rtc_wrap_counter #(.W(DAY_W), .MAX(DAY_MAX)) u_day (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_day),
      .step(step_day), .value(day), .at_max(day_top));

   assign roll_sec  = tick;
   assign roll_min  = step_min;
   assign roll_hour = step_hour;
   assign roll_day  = step_day;

   assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && day_top && hour_top && min_top && sec_top)
      |=> (day == '0 && hour == '0 && min == '0 && sec == '0));

   assert_minute_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && sec_top && !min_top) |=> min == $past(min) + MIN_W'(1));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
   import rtc_pkg::*;
#(
   parameter int DAY_W   = 15,
   parameter bit USE_DAY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TOD_W-1:0]  ld_tod,
   input  logic [DAY_W-1:0]  ld_day,
   input  logic              check,
   input  logic [SEC_W-1:0]  cur_sec,
   input  logic [MIN_W-1:0]  cur_min,
   input  logic [HOUR_W-1:0] cur_hour,
   input  logic [DAY_W-1:0]  cur_day,
   output logic [TOD_W-1:0]  tgt_tod,
   output logic [DAY_W-1:0]  tgt_day,
   output logic              hit
);

   logic tod_match, day_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tgt_tod <= '0;
      else if (load)  tgt_tod <= ld_tod;
   end

   assign tod_match = (tgt_tod == {cur_hour, cur_min, cur_sec});

   generate
      if (USE_DAY) begin : g_day
         logic [DAY_W-1:0] day_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     day_q <= '0;
            else if (load)  day_q <= ld_day;
         end
         assign day_match = (day_q == cur_day);
         assign tgt_day   = day_q;
      end else begin : g_tod_only
         logic unused_day;
         assign unused_day = ^{ld_day, cur_day};
         assign day_match  = 1'b1;
         assign tgt_day    = '0;
      end
   endgenerate

   assign hit = check & tod_match & day_match;

endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
   parameter int SW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SW_W-1:0] ld_val,
   input  logic            tick,
   output logic [SW_W-1:0] count,
   output logic            running,
   output logic            underflow
);

   generate
      if (SW_W < 1) begin : g_bad_sw
         $error("rtc_stopwatch: SW_W must be positive");
      end
   endgenerate

   assign underflow = tick & running & ~load & (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else if (load) begin
         count   <= ld_val;
         running <= 1'b1;
      end else if (tick && running) begin
         if (count == '0) running <= 1'b0;
         else             count   <= count - SW_W'(1);
      end
   end

   assert_stop_on_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> !running);

   assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && running && !load && count != '0) |=> count == $past(count) - SW_W'(1));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 32768,
   parameter int DAY_W    = 15,
   parameter int SW_W     = 16,
   localparam int DATA_W  = TOD_W + DAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   generate
      if (SW_W + 1 > DATA_W) begin : g_bad_sw_width
         $error("rtc_timekeeper: stopwatch does not fit the data word");
      end
   endgenerate

   logic time_wr, sw_wr, en_wr, flag_wr;
   logic sec_tick, check_q;
   logic [SEC_W-1:0]  sec;
   logic [MIN_W-1:0]  min;
   logic [HOUR_W-1:0] hour;
   logic [DAY_W-1:0]  day;
   logic r_sec, r_min, r_hour, r_day;
   logic [1:0]        hit;
   logic [TOD_W-1:0]  tgt_tod [2];
   logic [DAY_W-1:0]  tgt_day [2];
   logic [SW_W-1:0]   sw_cnt;
   logic              sw_run, sw_uf;
   logic [NUM_IRQ-1:0] evt, irq_en, flags, clr_mask;

   assign time_wr = wr_en & (wr_addr == REG_TIME);
   assign sw_wr   = wr_en & (wr_addr == REG_STOPWATCH);
   assign en_wr   = wr_en & (wr_addr == REG_IRQ_EN);
   assign flag_wr = wr_en & (wr_addr == REG_IRQ_FLAG);

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .restart(time_wr), .tick(sec_tick));

   rtc_counters #(.DAY_W(DAY_W)) u_counters (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(time_wr),
      .ld_sec(wr_data[5:0]), .ld_min(wr_data[11:6]),
      .ld_hour(wr_data[16:12]), .ld_day(wr_data[DATA_W-1:TOD_W]),
      .sec(sec), .min(min), .hour(hour), .day(day),
      .roll_sec(r_sec), .roll_min(r_min), .roll_hour(r_hour), .roll_day(r_day));

   // compare one cycle after the tick, once the counters hold the new time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) check_q <= 1'b0;
      else        check_q <= sec_tick;
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_alarm
         localparam reg_addr_e SLOT = (g == 0) ? REG_ALARM_TOD : REG_ALARM_FULL;
         rtc_alarm #(.DAY_W(DAY_W), .USE_DAY(g == 1)) u_alarm (
            .clk(clk), .rst_n(rst_n),
            .load(wr_en & (wr_addr == SLOT)),
            .ld_tod(wr_data[TOD_W-1:0]), .ld_day(wr_data[DATA_W-1:TOD_W]),
            .check(check_q),
            .cur_sec(sec), .cur_min(min), .cur_hour(hour), .cur_day(day),
            .tgt_tod(tgt_tod[g]), .tgt_day(tgt_day[g]), .hit(hit[g]));
      end
   endgenerate

   rtc_stopwatch #(.SW_W(SW_W)) u_stopwatch (
      .clk(clk), .rst_n(rst_n), .load(sw_wr), .ld_val(wr_data[SW_W-1:0]),
      .tick(sec_tick), .count(sw_cnt), .running(sw_run), .underflow(sw_uf));

   assign evt      = {sw_uf, hit[1], hit[0], r_day, r_hour, r_min, r_sec};
   assign clr_mask = flag_wr ? wr_data[NUM_IRQ-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en <= '0;
         flags  <= '0;
      end else begin
         if (en_wr) irq_en <= wr_data[NUM_IRQ-1:0];
         flags <= (flags & ~clr_mask) | (evt & irq_en);
      end
   end

   assign irq = |flags;

   always_comb begin
      case (reg_addr_e'(rd_addr))
         REG_TIME:       rd_data = {day, hour, min, sec};
         REG_ALARM_TOD:  rd_data = {{DAY_W{1'b0}}, tgt_tod[0]};
         REG_ALARM_FULL: rd_data = {tgt_day[1], tgt_tod[1]};
         REG_STOPWATCH:  rd_data = DATA_W'({sw_run, sw_cnt});
         REG_IRQ_EN:     rd_data = DATA_W'(irq_en);
         REG_IRQ_FLAG:   rd_data = DATA_W'(flags);
         default:        rd_data = '0;
      endcase
   end

   assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

   assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(irq_en)) == '0));

   assert_alarm_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != 2'b00) |-> $past(sec_tick));

endmodule

// File: tb/test_rtc_timekeeper.sv
module test_rtc_timekeeper;

   localparam int P     = 4;
   localparam int DW    = 15;
   localparam int SWW   = 16;
   localparam int DATAW = 17 + DW;
   localparam int DAYS  = 1 << DW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [DATAW-1:0] wr_data = '0;
   logic [2:0]       rd_addr = '0;
   logic [DATAW-1:0] rd_data;
   logic             irq;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit ph = 1'b0;

   always #10ns clk = ~clk;

   rtc_timekeeper #(.PRESCALE(P), .DAY_W(DW), .SW_W(SWW)) i_rtc_timekeeper (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq(irq));

   // behavioural reference model
   int m_pre, m_sec, m_min, m_hour, m_day, m_chk;
   int a_s, a_m, a_h, b_s, b_m, b_h, b_d;
   int m_sw, m_run, m_en, m_flags;

   initial begin
      m_pre = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_chk = 0;
      a_s = 0; a_m = 0; a_h = 0; b_s = 0; b_m = 0; b_h = 0; b_d = 0;
      m_sw = 0; m_run = 0; m_en = 0; m_flags = 0;
   end

   function automatic int clampv(int v, int mx);
      return (v > mx) ? mx : v;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_pre = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_chk = 0;
         a_s = 0; a_m = 0; a_h = 0; b_s = 0; b_m = 0; b_h = 0; b_d = 0;
         m_sw = 0; m_run = 0; m_en = 0; m_flags = 0;
      end else begin
         bit tw, sww, tk;
         int set;
         int d;
         tw  = wr_en && wr_addr == 3'd0;
         sww = wr_en && wr_addr == 3'd3;
         tk  = tick_en && m_pre == P - 1 && !tw;
         d   = int'(wr_data);
         set = 0;
         if (m_chk != 0) begin
            if (a_s == m_sec && a_m == m_min && a_h == m_hour) set |= 16;
            if (b_s == m_sec && b_m == m_min && b_h == m_hour && b_d == m_day) set |= 32;
         end
         if (tk) begin
            set |= 1;
            if (m_sec == 59) begin
               set |= 2;
               if (m_min == 59) begin
                  set |= 4;
                  if (m_hour == 23) set |= 8;
               end
            end
            if (m_run != 0 && !sww && m_sw == 0) set |= 64;
            if (m_sec < 59) m_sec++;
            else begin
               m_sec = 0;
               if (m_min < 59) m_min++;
               else begin
                  m_min = 0;
                  if (m_hour < 23) m_hour++;
                  else begin
                     m_hour = 0;
                     m_day = (m_day + 1) % DAYS;
                  end
               end
            end
            if (m_run != 0 && !sww) begin
               if (m_sw == 0) m_run = 0;
               else m_sw--;
            end
         end
         set &= m_en;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  m_sec  = clampv(d & 63, 59);
                  m_min  = clampv((d >> 6) & 63, 59);
                  m_hour = clampv((d >> 12) & 31, 23);
                  m_day  = (d >> 17) & (DAYS - 1);
               end
               3'd1: begin a_s = d & 63; a_m = (d >> 6) & 63; a_h = (d >> 12) & 31; end
               3'd2: begin
                  b_s = d & 63; b_m = (d >> 6) & 63; b_h = (d >> 12) & 31;
                  b_d = (d >> 17) & (DAYS - 1);
               end
               3'd3: begin m_sw = d & 16'hFFFF; m_run = 1; end
               3'd4: m_en = d & 127;
               3'd5: m_flags = m_flags & ~(d & 127);
               default: ;
            endcase
         end
         m_flags |= set;
         if (tw) m_pre = 0;
         else if (tick_en) m_pre = (m_pre + 1) % P;
         m_chk = tk ? 1 : 0;
      end
   end

   function automatic logic [DATAW-1:0] model_rd(logic [2:0] a);
      case (a)
         3'd0: return DATAW'((m_day << 17) | (m_hour << 12) | (m_min << 6) | m_sec);
         3'd1: return DATAW'((a_h << 12) | (a_m << 6) | a_s);
         3'd2: return DATAW'((b_d << 17) | (b_h << 12) | (b_m << 6) | b_s);
         3'd3: return DATAW'((m_run << 16) | m_sw);
         3'd4: return DATAW'(m_en);
         3'd5: return DATAW'(m_flags);
         default: return '0;
      endcase
   endfunction

   function automatic string addr_tag(logic [2:0] a);
      case (a)
         3'd0: return "R3";
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R8";
         3'd4: return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic expect_eq(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, compare against the model at the next negedge
   task automatic step();
      tick_en = ph;
      ph = ~ph;
      @(posedge clk);
      @(negedge clk);
      expect_eq(addr_tag(rd_addr), "model rd_data", rd_data, model_rd(rd_addr));
      expect_eq("R9", "model irq", irq, (m_flags != 0));
   endtask

   task automatic wr(logic [2:0] a, logic [DATAW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [DATAW-1:0] d);
      rd_addr = a;
      #1ns;
      d = rd_data;
   endtask

   task automatic wait_sec();
      logic [5:0] s;
      int guard;
      rd_addr = 3'd0;
      #1ns;
      s = rd_data[5:0];
      guard = 0;
      while (rd_data[5:0] == s && guard < 200) begin
         step();
         guard++;
      end
   endtask

   function automatic logic [DATAW-1:0] tw_word(int dd, int h, int m, int s);
      return DATAW'((dd << 17) | (h << 12) | (m << 6) | s);
   endfunction

   initial begin
      #2_000_000ns;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DATAW-1:0] v;
      int n;
      @(negedge clk);
      repeat (3) step();
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         expect_eq("R1", "reset register", v, 0);
      end
      expect_eq("R1", "reset irq", irq, 0);

      wr(3'd4, 32'h7F);
      wr(3'd1, tw_word(0, 10, 20, 33));
      wr(3'd2, tw_word(6, 10, 20, 33));
      rd_addr = 3'd0;
      wr(3'd0, tw_word(5, 10, 20, 30));

      // R2 count enabled edges up to the first tick after load
      n = 0;
      while (rd_data[5:0] == 6'd30 && n < 50) begin
         step();
         if (tick_en) n++;
      end
      expect_eq("R2", "enables to first tick", n, P);
      rd(3'd0, v);
      expect_eq("R3", "time after tick", v, tw_word(5, 10, 20, 31));

      wr(3'd5, 32'h7F);
      rd(3'd5, v);
      expect_eq("R9", "flags cleared", v, 0);

      // R6 time-of-day alarm at 10:20:33, full alarm is for day 6
      wait_sec();
      wait_sec();
      step();
      rd(3'd5, v);
      expect_eq("R6", "tod alarm fired", v & 32'h30, 32'h10);
      expect_eq("R9", "irq high", irq, 1);
      wr(3'd5, 32'h7F);
      rd(3'd5, v);
      expect_eq("R9", "w1c clears", v, 0);
      expect_eq("R9", "irq low", irq, 0);
      wait_sec();
      step();
      rd(3'd5, v);
      expect_eq("R6", "alarm fires once", v & 32'h10, 0);

      // R7 full alarm on day 6
      wr(3'd0, tw_word(6, 10, 20, 30));
      wr(3'd5, 32'h7F);
      wait_sec(); wait_sec(); wait_sec();
      step();
      rd(3'd5, v);
      expect_eq("R7", "both alarms fired", v & 32'h30, 32'h30);

      // R5 gating: only the second flag enabled across a minute rollover
      wr(3'd4, 32'h01);
      wr(3'd0, tw_word(0, 0, 59, 58));
      wr(3'd5, 32'h7F);
      wait_sec(); wait_sec();
      rd(3'd0, v);
      expect_eq("R3", "minute carry", v, tw_word(0, 1, 0, 0));
      rd(3'd5, v);
      expect_eq("R5", "disabled flags stay clear", v, 32'h01);

      // R4 day wrap with all tick flags
      wr(3'd4, 32'h0F);
      wr(3'd0, tw_word(DAYS - 1, 23, 59, 58));
      wr(3'd5, 32'h7F);
      wait_sec(); wait_sec();
      rd(3'd0, v);
      expect_eq("R4", "day wraps to zero", v, 0);
      rd(3'd5, v);
      expect_eq("R5", "rollover flags", v & 32'h0F, 32'h0F);

      // R3 clamping of out-of-range loads
      wr(3'd0, tw_word(3, 31, 62, 63));
      rd(3'd0, v);
      expect_eq("R3", "clamped load", v, tw_word(3, 23, 59, 59));

      // R8 stopwatch loaded with 3
      wr(3'd4, 32'h40);
      wr(3'd0, 0);
      wr(3'd5, 32'h7F);
      wr(3'd3, 32'd3);
      rd(3'd3, v);
      expect_eq("R8", "stopwatch loaded", v, 32'h10003);
      wait_sec(); wait_sec(); wait_sec();
      rd(3'd3, v);
      expect_eq("R8", "at zero still running", v, 32'h10000);
      rd(3'd5, v);
      expect_eq("R8", "no flag before underflow", v, 0);
      wait_sec();
      rd(3'd3, v);
      expect_eq("R8", "stopped after underflow", v, 0);
      rd(3'd5, v);
      expect_eq("R8", "underflow flag", v, 32'h40);

      // R8 underflow with enable cleared: stops, no flag
      wr(3'd4, 32'h00);
      wr(3'd5, 32'h7F);
      wr(3'd3, 32'd1);
      wait_sec(); wait_sec();
      rd(3'd3, v);
      expect_eq("R8", "disabled stopwatch stops", v, 0);
      rd(3'd5, v);
      expect_eq("R8", "disabled stopwatch no flag", v, 0);

      repeat (4) step();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule